// File: doc/BRIEF.md
# Looping Wavetable Sample Address Generator

This block steps a playback pointer through wavetable samples held in an external sound RAM for a bank of time-multiplexed voices. One voice is serviced per clock. The block fetches the two neighbouring samples the pointer straddles, blends them with the fractional part of the pointer, and applies the voice's sign-control bits. It then advances the pointer by a pitch step and folds it back into the voice's loop region according to that voice's loop mode.

The surrounding logic presents the configuration of the voice named by `voice_idx` in the same cycle. The external memory answers the two word addresses one clock later. Key-on restarts a voice. The block drives a pulse when a forward advance lands at or past the loop start, and another when a one-shot voice finishes. The envelope, the mixer and the RAM are not part of the block.

Top module: `wave_addr_gen`

## Requirements
- R1: One voice is serviced per clock. `voice_idx` is 0 after reset, counts up by one each cycle and returns to 0 after NUM_VOICES-1.
- R2: `key_on` in the cycle that voice v is serviced sets v's pointer to 0, direction forward, and makes v active. That cycle does no fetch. The first fetch happens at v's next service, starting at `start_addr`.
- R3: The pointer has 12 fraction bits. The step is (4096 + 4*fnum) shifted left by `octave` for octave 0..7, and shifted right by (16 - octave) for octave 8..15.
- R4: With `fmt_8bit`=0, the byte address is (start_addr + 2*int) with bit 0 cleared, kept to 19 bits. `mem_addr_a` is byte[18:1]. `mem_addr_b` is always `mem_addr_a`+1.
- R5: With `fmt_8bit`=1, the byte address is (start_addr + int) XOR 1, kept to 19 bits. The word is byte[18:1]. Byte bit 0 = 1 selects the word's high byte and 0 selects the low byte. The byte becomes the upper half of a 16-bit sample. The next sample uses int+1.
- R6: `smp_out` = (A*(4096-f) + B*f) >>> 12, where A and B are the current and next samples and f is the fraction. The result is valid with `smp_valid` and `smp_voice` in the cycle after the fetch.
- R7: `sign_ctl` bit 0 XORs the sample with 0x7FFF, and bit 1 XORs it with 0x8000.
- R8: Loop mode 0 (one-shot): an advance whose integer part is at or past both loop start and loop end pulses `voice_stop`. The voice then becomes inactive and makes no further fetches.
- R9: Loop mode 1 (forward loop): an advance at or past loop end moves the pointer to loop start plus the overshoot past loop end.
- R10: Loop mode 2 (reverse): a forward advance at or past loop start jumps to loop end minus the overshoot, and the direction becomes backward. Falling below loop start while backward jumps to loop end minus the shortfall.
- R11: Loop mode 3 (ping-pong): reaching loop end turns the pointer back to end minus the overshoot. Falling below loop start, or below zero (bit 31 set), resumes forward play at start plus the shortfall.
- R12: `loop_hit` pulses alongside the sample of every forward advance whose integer part is at or past loop start. A backward advance never pulses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| voice_idx | output | VW | Voice serviced this cycle |
| key_on | input | 1 | Restart the serviced voice |
| start_addr | input | SA_W | Sample start byte address |
| loop_start | input | LOOP_W | Loop start, in samples |
| loop_end | input | LOOP_W | Loop end, in samples |
| loop_mode | input | 2 | 0 one-shot, 1 forward, 2 reverse, 3 ping-pong |
| fmt_8bit | input | 1 | 1: 8-bit samples, 0: 16-bit |
| octave | input | 4 | Signed octave shift |
| fnum | input | 10 | Pitch fine number |
| sign_ctl | input | 2 | Sample sign-inversion controls |
| mem_rd | output | 1 | Fetch issued this cycle |
| mem_addr_a | output | MEM_AW | Word address of current sample |
| mem_addr_b | output | MEM_AW | Word address of next sample |
| mem_data_a | input | 16 | Word read at mem_addr_a, one clock later |
| mem_data_b | input | 16 | Word read at mem_addr_b, one clock later |
| smp_valid | output | 1 | Sample output valid |
| smp_voice | output | VW | Voice of the output sample |
| smp_out | output | 16 | Interpolated, sign-controlled sample |
| loop_hit | output | 1 | Forward advance reached loop start |
| voice_stop | output | 1 | One-shot voice ended |

## Verification
The assertions check these properties on every cycle: the service order of the voices, the one-word spacing of the two 16-bit fetch addresses, the floor on the step for non-negative octaves, and the pass-through of an unblended, unaltered 16-bit sample. The wrap arithmetic of each loop mode, the reversal points, recovery from a pointer that went negative, the end of a one-shot voice, and the exact pitch steps depend on long trajectories. Only the bench's scenarios show those, because they compare the sequences of fetched addresses against hand-derived ones.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int FRAC_W = 12;
  localparam int FNUM_W = 10;
  localparam int OCT_W  = 4;
  localparam int ACC_W  = 32;
  localparam int SMP_W  = 16;
  localparam int BASE_W = FRAC_W + 1;
  localparam int STEP_W = BASE_W + (1 << (OCT_W - 1)) - 1;

  typedef enum logic [1:0] {
    LOOP_ONESHOT  = 2'd0,
    LOOP_FORWARD  = 2'd1,
    LOOP_REVERSE  = 2'd2,
    LOOP_PINGPONG = 2'd3
  } loop_mode_e;
endpackage

// File: rtl/wag_pitch_step.sv
module wag_pitch_step
  import wag_pkg::*;
(
  input  logic [OCT_W-1:0]  octave,
  input  logic [FNUM_W-1:0] fnum,
  output logic [STEP_W-1:0] step
);
  localparam int FN_SH = FRAC_W - FNUM_W;

  logic [STEP_W-1:0] base_x;
  logic [OCT_W:0]    rsh;

  always_comb begin
    base_x = STEP_W'((BASE_W'(1) << FRAC_W) + (BASE_W'(fnum) << FN_SH));
    rsh    = (OCT_W+1)'(1 << OCT_W) - {1'b0, octave};
    if (octave[OCT_W-1])
      step = base_x >> rsh;
    else
      step = base_x << octave[OCT_W-2:0];
  end
endmodule

// File: rtl/wag_loop_unit.sv
module wag_loop_unit
  import wag_pkg::*;
#(
  parameter int LOOP_W = 16
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              bwd_i,
  input  logic [STEP_W-1:0] step,
  input  loop_mode_e        mode,
  input  logic [LOOP_W-1:0] lsa,
  input  logic [LOOP_W-1:0] lea,
  output logic [ACC_W-1:0]  acc_o,
  output logic              bwd_o,
  output logic              stop_o,
  output logic              hit_o
);
  logic [ACC_W-1:0] adv, lsa_f, lea_f;
  logic ge_ls, ge_le, neg;

  always_comb begin
    lsa_f  = ACC_W'({lsa, {FRAC_W{1'b0}}});
    lea_f  = ACC_W'({lea, {FRAC_W{1'b0}}});
    adv    = bwd_i ? acc_i - ACC_W'(step) : acc_i + ACC_W'(step);
    neg    = adv[ACC_W-1];
    ge_ls  = adv >= lsa_f;
    ge_le  = adv >= lea_f;
    hit_o  = ge_ls & ~bwd_i;
    acc_o  = adv;
    bwd_o  = bwd_i;
    stop_o = 1'b0;
    unique case (mode)
      LOOP_ONESHOT: begin
        if (ge_ls && ge_le) stop_o = 1'b1;
      end
      LOOP_FORWARD: begin
        if (ge_le) acc_o = lsa_f + (adv - lea_f);
      end
      LOOP_REVERSE: begin
        if (ge_ls && !bwd_i) begin
          acc_o = lea_f - (adv - lsa_f);
          bwd_o = 1'b1;
        end else if ((!ge_ls || neg) && bwd_i) begin
          acc_o = lea_f - (lsa_f - adv);
        end
      end
      default: begin
        if (ge_le && !neg) begin
          acc_o = lea_f - (adv - lea_f);
          bwd_o = 1'b1;
        end else if ((!ge_ls || neg) && bwd_i) begin
          acc_o = lsa_f + (lsa_f - adv);
          bwd_o = 1'b0;
        end
      end
    endcase
  end
endmodule

// File: rtl/wag_interp.sv
module wag_interp
  import wag_pkg::*;
(
  input  logic [SMP_W-1:0]  d0,
  input  logic [SMP_W-1:0]  d1,
  input  logic              is8,
  input  logic              lane0,
  input  logic              lane1,
  input  logic [FRAC_W-1:0] frac,
  input  logic [1:0]        sctl,
  output logic [SMP_W-1:0]  smp
);
  logic signed [ACC_W-1:0] e0, e1, f0, f1, mix, res;
  logic [SMP_W-1:0] s0, s1;
  logic unused_res;

  always_comb begin
    s0  = is8 ? {(lane0 ? d0[SMP_W-1:8] : d0[7:0]), {(SMP_W-8){1'b0}}} : d0;
    s1  = is8 ? {(lane1 ? d1[SMP_W-1:8] : d1[7:0]), {(SMP_W-8){1'b0}}} : d1;
    e0  = ACC_W'($signed(s0));
    e1  = ACC_W'($signed(s1));
    f1  = ACC_W'(frac);
    f0  = ACC_W'(1 << FRAC_W) - f1;
    mix = e0 * f0 + e1 * f1;
    res = mix >>> FRAC_W;
    smp = res[SMP_W-1:0] ^ {sctl[1], {(SMP_W-1){sctl[0]}}};
  end

  assign unused_res = &{1'b0, res[ACC_W-1:SMP_W]};
endmodule

// File: rtl/wave_addr_gen.sv
module wave_addr_gen
  import wag_pkg::*;
#(
  parameter int NUM_VOICES = 32,
  parameter int SA_W       = 20,
  parameter int LOOP_W     = 16,
  parameter int MEM_AW     = 18,
  localparam int VW        = $clog2(NUM_VOICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [VW-1:0]     voice_idx,
  input  logic              key_on,
  input  logic [SA_W-1:0]   start_addr,
  input  logic [LOOP_W-1:0] loop_start,
  input  logic [LOOP_W-1:0] loop_end,
  input  logic [1:0]        loop_mode,
  input  logic              fmt_8bit,
  input  logic [OCT_W-1:0]  octave,
  input  logic [FNUM_W-1:0] fnum,
  input  logic [1:0]        sign_ctl,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr_a,
  output logic [MEM_AW-1:0] mem_addr_b,
  input  logic [SMP_W-1:0]  mem_data_a,
  input  logic [SMP_W-1:0]  mem_data_b,
  output logic              smp_valid,
  output logic [VW-1:0]     smp_voice,
  output logic [SMP_W-1:0]  smp_out,
  output logic              loop_hit,
  output logic              voice_stop
);
  localparam int BYTE_AW = MEM_AW + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // per-voice state
  logic [ACC_W-1:0]      acc_q [NUM_VOICES];
  logic                  bwd_q [NUM_VOICES];
  logic [NUM_VOICES-1:0] act_q;
  logic [VW-1:0]         vcnt_q, vcnt_d;

  logic [ACC_W-1:0] cur_acc, acc_d, lp_acc;
  logic             cur_bwd, cur_act, bwd_d, act_d, wr_en, fire;
  logic             lp_bwd, lp_stop, lp_hit;
  logic [STEP_W-1:0] step_w;

  assign cur_acc = acc_q[vcnt_q];
  assign cur_bwd = bwd_q[vcnt_q];
  assign cur_act = act_q[vcnt_q];

  // fetch addresses
  logic [SA_W-1:0] off_a, off_b, sum_a, sum_b;
  logic            lane_a, lane_b;
  logic            unused_bits;

  always_comb begin
    off_a  = fmt_8bit ? SA_W'(cur_acc[ACC_W-1:FRAC_W])
                      : SA_W'({cur_acc[ACC_W-1:FRAC_W], 1'b0});
    off_b  = fmt_8bit ? off_a + SA_W'(1) : off_a + SA_W'(2);
    sum_a  = start_addr + off_a;
    sum_b  = start_addr + off_b;
    lane_a = fmt_8bit & ~sum_a[0];
    lane_b = fmt_8bit & ~sum_b[0];
  end

  assign mem_addr_a  = sum_a[BYTE_AW-1:1];
  assign mem_addr_b  = sum_b[BYTE_AW-1:1];
  assign unused_bits = &{1'b0, sum_a[SA_W-1:BYTE_AW], sum_b[SA_W-1:BYTE_AW]};
  assign fire        = cur_act & ~key_on;
  assign mem_rd      = fire;

  wag_pitch_step u_step (
    .octave (octave),
    .fnum   (fnum),
    .step   (step_w)
  );

  wag_loop_unit #(.LOOP_W(LOOP_W)) u_loop (
    .acc_i  (cur_acc),
    .bwd_i  (cur_bwd),
    .step   (step_w),
    .mode   (loop_mode_e'(loop_mode)),
    .lsa    (loop_start),
    .lea    (loop_end),
    .acc_o  (lp_acc),
    .bwd_o  (lp_bwd),
    .stop_o (lp_stop),
    .hit_o  (lp_hit)
  );

  // next state
  always_comb begin
    wr_en  = key_on | fire;
    acc_d  = lp_acc;
    bwd_d  = lp_bwd;
    act_d  = ~lp_stop;
    if (key_on) begin
      acc_d = '0;
      bwd_d = 1'b0;
      act_d = 1'b1;
    end
    vcnt_d = (vcnt_q == VW'(NUM_VOICES - 1)) ? '0 : vcnt_q + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q <= '0;
      act_q  <= '0;
    end else begin
      vcnt_q <= vcnt_d;
      if (wr_en) act_q[vcnt_q] <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      acc_q[vcnt_q] <= acc_d;
      bwd_q[vcnt_q] <= bwd_d;
    end
  end

  // sample stage
  logic              b_vld, b_ls, b_stop, b_8, b_la, b_lb;
  logic [VW-1:0]     b_voice;
  logic [FRAC_W-1:0] b_frac;
  logic [1:0]        b_sctl;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      b_vld  <= 1'b0;
      b_ls   <= 1'b0;
      b_stop <= 1'b0;
    end else begin
      b_vld  <= fire;
      b_ls   <= fire & lp_hit;
      b_stop <= fire & lp_stop;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      b_voice <= vcnt_q;
      b_frac  <= cur_acc[FRAC_W-1:0];
      b_8     <= fmt_8bit;
      b_la    <= lane_a;
      b_lb    <= lane_b;
      b_sctl  <= sign_ctl;
    end
  end

  wag_interp u_interp (
    .d0    (mem_data_a),
    .d1    (mem_data_b),
    .is8   (b_8),
    .lane0 (b_la),
    .lane1 (b_lb),
    .frac  (b_frac),
    .sctl  (b_sctl),
    .smp   (smp_out)
  );

  assign voice_idx  = vcnt_q;
  assign smp_valid  = b_vld;
  assign smp_voice  = b_voice;
  assign loop_hit   = b_ls;
  assign voice_stop = b_stop;

  // R1
  voice_seq_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (voice_idx != VW'(NUM_VOICES - 1)) |=> (voice_idx == VW'($past(voice_idx) + VW'(1))));

  // R4
  pair_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_rd && !fmt_8bit) |-> (mem_addr_b == mem_addr_a + MEM_AW'(1)));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!octave[OCT_W-1]) |-> (step_w >= STEP_W'(1 << FRAC_W)));

  // R6
  interp_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (smp_valid && b_frac == '0 && b_sctl == 2'b00 && !b_8) |-> (smp_out == mem_data_a));
endmodule

// File: tb/test_wave_addr_gen.sv
module test_wave_addr_gen;
  localparam int NV = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, key_on, fmt_8bit, mem_rd, smp_valid, loop_hit, voice_stop;
  logic [1:0]  voice_idx, smp_voice, loop_mode, sign_ctl;
  logic [19:0] start_addr;
  logic [15:0] loop_start, loop_end, mem_data_a, mem_data_b, smp_out;
  logic [3:0]  octave;
  logic [9:0]  fnum;
  logic [17:0] mem_addr_a, mem_addr_b;

  wave_addr_gen #(.NUM_VOICES(NV)) i_wave_addr_gen (
    .clk(clk), .rst_n(rst_n), .voice_idx(voice_idx), .key_on(key_on),
    .start_addr(start_addr), .loop_start(loop_start), .loop_end(loop_end),
    .loop_mode(loop_mode), .fmt_8bit(fmt_8bit), .octave(octave), .fnum(fnum),
    .sign_ctl(sign_ctl), .mem_rd(mem_rd), .mem_addr_a(mem_addr_a),
    .mem_addr_b(mem_addr_b), .mem_data_a(mem_data_a), .mem_data_b(mem_data_b),
    .smp_valid(smp_valid), .smp_voice(smp_voice), .smp_out(smp_out),
    .loop_hit(loop_hit), .voice_stop(voice_stop)
  );

  function automatic logic [15:0] patt(input logic [17:0] w);
    logic [31:0] t;
    t = ({14'd0, w} * 32'h9E37) ^ 32'h5A3C;
    return t[15:0];
  endfunction

  always @(posedge clk) begin
    mem_data_a <= patt(mem_addr_a);
    mem_data_b <= patt(mem_addr_b);
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // visit records
  int v_a, v_b, v_rd, v_vld, v_voice, v_smp, v_ls, v_stop;

  task automatic visit();
    do @(negedge clk); while (voice_idx != 2'd0);
    v_a = int'(mem_addr_a); v_b = int'(mem_addr_b); v_rd = int'(mem_rd);
    @(negedge clk);
    v_vld = int'(smp_valid); v_voice = int'(smp_voice); v_smp = int'(smp_out);
    v_ls = int'(loop_hit); v_stop = int'(voice_stop);
  endtask

  task automatic start_voice();
    do @(negedge clk); while (voice_idx != 2'd0);
    key_on = 1'b1;
    @(negedge clk);
    key_on = 1'b0;
  endtask

  task automatic setup(input int mode, input int ls, input int le, input int oc, input int fn);
    loop_mode = 2'(mode); loop_start = 16'(ls); loop_end = 16'(le);
    octave = 4'(oc); fnum = 10'(fn);
    start_addr = '0; fmt_8bit = 1'b0; sign_ctl = 2'b00;
  endtask

  // octave, fnum, integer position after 16 advances
  localparam int VEC [7][3] = '{
    '{0, 0, 16}, '{1, 0, 32}, '{15, 0, 8}, '{0, 512, 24},
    '{2, 1023, 127}, '{12, 1023, 1}, '{7, 0, 2048}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    wrap_up();
  end

  initial begin
    int prev, s0, s1, e;
    rst_n = 1'b0; key_on = 1'b0;
    setup(1, 0, 16'hFFFF, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset voice_idx", int'(voice_idx), 0);
    chk("R1 reset smp_valid", int'(smp_valid), 0);
    chk("R12 reset loop_hit", int'(loop_hit), 0);
    chk("R8 reset voice_stop", int'(voice_stop), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    prev = int'(voice_idx);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R1 voice order", int'(voice_idx), (prev + 1) % NV);
      prev = int'(voice_idx);
    end

    // R3 pitch table, R2 key-on start, R4 pair spacing
    for (int i = 0; i < 7; i++) begin
      setup(1, 0, 16'hFFFF, VEC[i][0], VEC[i][1]);
      start_voice();
      visit();
      chk("R2 first fetch at start", v_a, 0);
      chk("R2 fetch issued", v_rd, 1);
      for (int k = 0; k < 16; k++) visit();
      chk("R3 position after 16 steps", v_a, VEC[i][2]);
      chk("R4 next word", v_b, VEC[i][2] + 1);
    end

    // R9 forward loop, step 1.5, R6 interpolation, R12
    begin
      int exp1 [12] = '{0, 1, 3, 4, 6, 7, 5, 6, 4, 5, 7, 4};
      setup(1, 4, 8, 0, 512);
      start_voice();
      for (int k = 0; k < 12; k++) begin
        visit();
        chk("R9 forward loop address", v_a, exp1[k]);
        if (k == 1) begin
          s0 = int'($signed(patt(18'(1))));
          s1 = int'($signed(patt(18'(2))));
          e  = (s0 * 2048 + s1 * 2048) >>> 12;
          chk("R6 half-way blend", v_smp, e & 16'hFFFF);
          chk("R6 sample voice tag", v_voice, 0);
          chk("R12 no hit before loop start", v_ls, 0);
        end
        if (k == 2) chk("R12 hit at loop start", v_ls, 1);
      end
    end

    // R5 8-bit lanes, R7 sign control
    for (int sc = 0; sc < 4; sc++) begin
      setup(1, 0, 16'hFFFF, 0, 0);
      fmt_8bit = 1'b1; start_addr = 20'h10; sign_ctl = 2'(sc);
      start_voice();
      visit();
      e = {patt(18'd8) >> 8, 8'h00};
      if (sc[0]) e = e ^ 16'h7FFF;
      if (sc[1]) e = e ^ 16'h8000;
      chk("R7 sign control on 8-bit sample", v_smp, e);
      if (sc == 0) begin
        chk("R5 8-bit word", v_a, 8);
        visit();
        chk("R5 8-bit next word", v_b, 9);
      end
    end

    // R8 one-shot
    setup(0, 2, 3, 0, 0);
    start_voice();
    visit(); chk("R8 addr 0", v_a, 0); chk("R8 no stop yet", v_stop, 0);
    visit(); chk("R12 hit at start", v_ls, 1);
    visit(); chk("R8 stop pulse", v_stop, 1);
    visit(); chk("R8 no fetch after stop", v_rd, 0);
    chk("R8 no sample after stop", v_vld, 0);

    // R10 reverse loop
    begin
      int exp2 [9] = '{0, 1, 3, 9, 8, 6, 5, 9, 8};
      setup(2, 4, 10, 0, 512);
      start_voice();
      for (int k = 0; k < 9; k++) begin
        visit();
        chk("R10 reverse loop address", v_a, exp2[k]);
        if (k == 3) chk("R12 no hit when backward", v_ls, 0);
      end
    end

    // R11 ping-pong
    begin
      int exp3 [12] = '{0, 1, 3, 4, 6, 7, 7, 5, 4, 5, 7, 7};
      setup(3, 4, 8, 0, 512);
      start_voice();
      for (int k = 0; k < 12; k++) begin
        visit();
        chk("R11 ping-pong address", v_a, exp3[k]);
      end
    end

    // R11 ping-pong through a negative pointer
    begin
      int exp4 [13] = '{0, 1, 3, 4, 6, 7, 7, 5, 4, 2, 1, 0, 2};
      setup(3, 0, 8, 0, 512);
      start_voice();
      for (int k = 0; k < 13; k++) begin
        visit();
        chk("R11 negative recovery address", v_a, exp4[k]);
      end
    end

    wrap_up();
  end
endmodule